// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control registers of a processor core. Software reaches them through one register index, a write strobe with a 64-bit write-data bus, and a read strobe with a combinational read port. Each index has its own write rule: some registers take the whole word, some keep only a field, some are cleared by any write, some may only be read, and some may only be written. An access that breaks the rule for its index raises a fault flag in the same cycle, so the pipeline can turn it into an illegal-operation trap.

One register gives a cycle-count view. Its upper half is stored and its lower half is a free-running counter. Writes to the translation-buffer invalidate registers do not go to a translation buffer inside the block. They come out as single-cycle pulses, and the single-entry invalidate also carries the address and the current instruction address-space number. An exception-posting input lets hardware set bits in the exception summary and mask registers, and software clears those registers by writing to them.

Top module: `ctrlreg_bank`

## Requirements
- R1: One cycle after reset is released, a read returns 0x6 from the control/status register (index 9), VEC_RESET from the vector-base register (index 8), and zero from every other readable register, including the lower half of the cycle-count view.
- R2: The scratch registers (indices 0 to SCRATCH_N-1), the vector-base register (8) and the control/status register (9) store the full write word. A write to the cycle-count register (25) stores only its upper 32 bits.
- R3: A write to the exception-PC register (10) stores the data with bit 1 forced to zero.
- R4: The trap-request (11) and trap-enable (12) registers keep only bits 3:0 of the write data.
- R5: The instruction-mode (13) and data-mode (14) registers keep only bits 4:3 (mask 0x18). The output user_mode is high exactly when the stored data-mode bits are nonzero.
- R6: Other field masks on write: instruction ASN (21) keeps 0x7F0, data ASN (22) keeps bits 63:57, page-table base (23) keeps bits 63:30, cache mode (24) keeps 0x3F.
- R7: Exception summary (15) and exception mask (16) are cleared by any write, whatever the data. Each cycle the bits of exc_post are ORed into both registers, and a post in the same cycle as a clearing write survives the clear.
- R8: Writes to the read-only indices 17 to 20 raise fault and change nothing. Reads of these indices return zero without a fault.
- R9: Reads of the write-only indices 32 to 38 return zero and raise fault. Writes to these indices do not fault.
- R10: Any access to an unassigned index (SCRATCH_N to 7, 26 to 31, 39 to 63) raises fault, both on read and on write. fault is combinational with the access, and it is low in any cycle with no strobe.
- R11: A read of index 25 returns the stored upper 32 bits concatenated with a 32-bit counter. The counter is zero at reset release and advances by one on every clock.
- R12: In the cycle after a write to index 36, 37 or 38, exactly one of inv_all_p, inv_proc_p or inv_one_p is high, for one cycle. Together with inv_one_p, inv_addr carries the write data and inv_asn carries bits 10:4 of the instruction ASN register as it was before that write.
- R13: rdata is zero whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idx | input | 6 | Register index for the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 64 | Write data |
| exc_post | input | 64 | Exception bits ORed into the summary and mask registers |
| rdata | output | 64 | Read data, combinational |
| fault | output | 1 | Illegal access in this cycle |
| user_mode | output | 1 | Data-mode register is nonzero |
| inv_all_p | output | 1 | Invalidate-all pulse |
| inv_proc_p | output | 1 | Invalidate-process pulse |
| inv_one_p | output | 1 | Invalidate-single pulse |
| inv_addr | output | 64 | Address for the single invalidate |
| inv_asn | output | 7 | Address-space number for the single invalidate |

## Verification
The bench builds the bank with SCRATCH_N = 4 and a nonzero VEC_RESET. With four scratch registers, indices 4 to 7 are unassigned, so the boundary between scratch space and fault space can be checked next to the reserved gaps higher up. A distinctive vector-base reset value shows whether the reset loads the parameter or zero. The 32-bit counter slice is compared against a counter kept in the bench on every read of the cycle-count view, and a long random phase mixes all indices, strobes and posted exception bits.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

    localparam int DW   = 64;
    localparam int IDXW = 6;

    typedef logic [IDXW-1:0] idx_t;

    // full-word registers and the exception/mode group
    localparam idx_t IX_VECBASE  = 6'd8;
    localparam idx_t IX_CSR      = 6'd9;
    localparam idx_t IX_EXCPC    = 6'd10;
    localparam idx_t IX_TRAPREQ  = 6'd11;
    localparam idx_t IX_TRAPEN   = 6'd12;
    localparam idx_t IX_IMODE    = 6'd13;
    localparam idx_t IX_DMODE    = 6'd14;
    localparam idx_t IX_EXCSUM   = 6'd15;
    localparam idx_t IX_EXCMASK  = 6'd16;
    // read-only window
    localparam idx_t IX_RO_FIRST = 6'd17;
    localparam idx_t IX_RO_LAST  = 6'd20;
    // masked registers and the cycle view
    localparam idx_t IX_IASN     = 6'd21;
    localparam idx_t IX_DASN     = 6'd22;
    localparam idx_t IX_PTBASE   = 6'd23;
    localparam idx_t IX_CMODE    = 6'd24;
    localparam idx_t IX_CYC      = 6'd25;
    // write-only window
    localparam idx_t IX_WO_FIRST = 6'd32;
    localparam idx_t IX_INV_ALL  = 6'd36;
    localparam idx_t IX_INV_PROC = 6'd37;
    localparam idx_t IX_INV_ONE  = 6'd38;
    localparam idx_t IX_WO_LAST  = 6'd38;

    localparam logic [DW-1:0] CSR_RESET = 64'h6;
    localparam int CNT_W = 32;
    localparam int ASN_W = 7;

endpackage

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode
    import ctrlreg_pkg::*;
#(
    parameter int SCRATCH_N = 4
) (
    input  idx_t idx,
    output logic is_scr,
    output logic readable,
    output logic writable
);
    logic in_main;
    logic in_ro;
    logic in_wo;

    always_comb begin
        is_scr  = (32'(idx) < SCRATCH_N);
        in_main = ((idx >= IX_VECBASE) && (idx < IX_RO_FIRST)) ||
                  ((idx >= IX_IASN) && (idx <= IX_CYC));
        in_ro   = (idx >= IX_RO_FIRST) && (idx <= IX_RO_LAST);
        in_wo   = (idx >= IX_WO_FIRST) && (idx <= IX_WO_LAST);
        readable = is_scr || in_main || in_ro;
        writable = is_scr || in_main || in_wo;
    end
endmodule

// File: rtl/ctrlreg_tick.sv
module ctrlreg_tick #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ctrlreg_bank.sv
module ctrlreg_bank
    import ctrlreg_pkg::*;
#(
    parameter int          SCRATCH_N = 4,
    parameter logic [63:0] VEC_RESET = 64'h0000_0000_0001_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  idx,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [63:0] wdata,
    input  logic [63:0] exc_post,
    output logic [63:0] rdata,
    output logic        fault,
    output logic        user_mode,
    output logic        inv_all_p,
    output logic        inv_proc_p,
    output logic        inv_one_p,
    output logic [63:0] inv_addr,
    output logic [6:0]  inv_asn
);
    localparam int HI_W = DW - CNT_W;

    typedef struct packed {
        logic [SCRATCH_N-1:0][DW-1:0] scr;
        logic [DW-1:0]    vecbase;
        logic [DW-1:0]    csr;
        logic [DW-1:0]    excpc;
        logic [3:0]       trapreq;
        logic [3:0]       trapen;
        logic [1:0]       imode;
        logic [1:0]       dmode;
        logic [DW-1:0]    excsum;
        logic [DW-1:0]    excmask;
        logic [ASN_W-1:0] iasn;
        logic [ASN_W-1:0] dasn;
        logic [33:0]      ptbase;
        logic [5:0]       cmode;
        logic [HI_W-1:0]  cyc_hi;
        logic             inv_all;
        logic             inv_proc;
        logic             inv_one;
        logic [DW-1:0]    inv_addr;
        logic [ASN_W-1:0] inv_asn;
    } bank_t;

    bank_t s_d, s_q;

    logic             is_scr, readable, writable, wr_ok;
    logic [CNT_W-1:0] cnt;
    logic [DW-1:0]    rview;

    ctrlreg_decode #(.SCRATCH_N(SCRATCH_N)) u_dec (
        .idx      (idx),
        .is_scr   (is_scr),
        .readable (readable),
        .writable (writable)
    );

    ctrlreg_tick #(.W(CNT_W)) u_tick (
        .clk (clk),
        .rst (rst),
        .cnt (cnt)
    );

    assign wr_ok = wr_en && writable;

    // next-state
    always_comb begin
        s_d          = s_q;
        s_d.inv_all  = 1'b0;
        s_d.inv_proc = 1'b0;
        s_d.inv_one  = 1'b0;

        s_d.excsum  = ((wr_ok && idx == IX_EXCSUM)  ? '0 : s_q.excsum)  | exc_post;
        s_d.excmask = ((wr_ok && idx == IX_EXCMASK) ? '0 : s_q.excmask) | exc_post;

        for (int k = 0; k < SCRATCH_N; k++) begin
            if (wr_ok && 32'(idx) == k) s_d.scr[k] = wdata;
        end

        if (wr_ok) begin
            case (idx)
                IX_VECBASE:  s_d.vecbase = wdata;
                IX_CSR:      s_d.csr     = wdata;
                IX_EXCPC:    s_d.excpc   = {wdata[63:2], 1'b0, wdata[0]};
                IX_TRAPREQ:  s_d.trapreq = wdata[3:0];
                IX_TRAPEN:   s_d.trapen  = wdata[3:0];
                IX_IMODE:    s_d.imode   = wdata[4:3];
                IX_DMODE:    s_d.dmode   = wdata[4:3];
                IX_IASN:     s_d.iasn    = wdata[10:4];
                IX_DASN:     s_d.dasn    = wdata[63:57];
                IX_PTBASE:   s_d.ptbase  = wdata[63:30];
                IX_CMODE:    s_d.cmode   = wdata[5:0];
                IX_CYC:      s_d.cyc_hi  = wdata[DW-1:CNT_W];
                IX_INV_ALL:  s_d.inv_all  = 1'b1;
                IX_INV_PROC: s_d.inv_proc = 1'b1;
                IX_INV_ONE: begin
                    s_d.inv_one  = 1'b1;
                    s_d.inv_addr = wdata;
                    s_d.inv_asn  = s_q.iasn;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q         <= '0;
            s_q.vecbase <= VEC_RESET;
            s_q.csr     <= CSR_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    // read view
    always_comb begin
        rview = '0;
        case (idx)
            IX_VECBASE: rview = s_q.vecbase;
            IX_CSR:     rview = s_q.csr;
            IX_EXCPC:   rview = s_q.excpc;
            IX_TRAPREQ: rview = {60'b0, s_q.trapreq};
            IX_TRAPEN:  rview = {60'b0, s_q.trapen};
            IX_IMODE:   rview = {59'b0, s_q.imode, 3'b0};
            IX_DMODE:   rview = {59'b0, s_q.dmode, 3'b0};
            IX_EXCSUM:  rview = s_q.excsum;
            IX_EXCMASK: rview = s_q.excmask;
            IX_IASN:    rview = {53'b0, s_q.iasn, 4'b0};
            IX_DASN:    rview = {s_q.dasn, 57'b0};
            IX_PTBASE:  rview = {s_q.ptbase, 30'b0};
            IX_CMODE:   rview = {58'b0, s_q.cmode};
            IX_CYC:     rview = {s_q.cyc_hi, cnt};
            default:    rview = '0;
        endcase
        for (int k = 0; k < SCRATCH_N; k++) begin
            if (32'(idx) == k) rview = s_q.scr[k];
        end
    end

    assign rdata      = (rd_en && readable) ? rview : '0;
    assign fault      = (rd_en && !readable) || (wr_en && !writable);
    assign user_mode  = |s_q.dmode;
    assign inv_all_p  = s_q.inv_all;
    assign inv_proc_p = s_q.inv_proc;
    assign inv_one_p  = s_q.inv_one;
    assign inv_addr   = s_q.inv_addr;
    assign inv_asn    = s_q.inv_asn;
endmodule

// File: rtl/ctrlreg_bank_chk.sv
module ctrlreg_bank_chk
    import ctrlreg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [5:0]  idx,
    input logic        wr_en,
    input logic        rd_en,
    input logic [63:0] rdata,
    input logic        fault,
    input logic        user_mode,
    input logic        inv_all_p,
    input logic        inv_proc_p,
    input logic        inv_one_p
);
    // R10
    quiet_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rd_en) |-> !fault);

    // R12
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inv_all_p, inv_proc_p, inv_one_p}));

    // R12
    inv_all_src_chk: assert property (@(posedge clk) disable iff (rst)
        inv_all_p |-> $past(wr_en && idx == IX_INV_ALL));

    // R3
    excpc_bit1_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx == IX_EXCPC) |-> !rdata[1]);

    // R4
    trap_width_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (idx == IX_TRAPREQ || idx == IX_TRAPEN)) |-> (rdata[63:4] == '0));

    // R9
    wo_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx >= IX_WO_FIRST && idx <= IX_WO_LAST) |-> (fault && rdata == '0));

    // R5
    mode_view_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx == IX_DMODE) |-> (user_mode == (rdata != '0)));
endmodule

bind ctrlreg_bank ctrlreg_bank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .idx        (idx),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .fault      (fault),
    .user_mode  (user_mode),
    .inv_all_p  (inv_all_p),
    .inv_proc_p (inv_proc_p),
    .inv_one_p  (inv_one_p)
);

// File: tb/ctrlreg_bank_test.sv
`timescale 1ns/1ps
module ctrlreg_bank_test;
    localparam logic [63:0] VEC = 64'hFFFF_8000_0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  idx = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [63:0] wdata = '0, exc_post = '0;
    logic [63:0] rdata, inv_addr;
    logic        fault, user_mode, inv_all_p, inv_proc_p, inv_one_p;
    logic [6:0]  inv_asn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [63:0] m [int];
    int unsigned m_cnt;
    bit e_all, e_proc, e_one;
    logic [63:0] e_addr;
    logic [6:0]  e_asn;

    always #2 clk = ~clk;

    ctrlreg_bank #(.SCRATCH_N(4), .VEC_RESET(VEC)) uut (
        .clk(clk), .rst(rst), .idx(idx), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .exc_post(exc_post), .rdata(rdata), .fault(fault),
        .user_mode(user_mode), .inv_all_p(inv_all_p), .inv_proc_p(inv_proc_p),
        .inv_one_p(inv_one_p), .inv_addr(inv_addr), .inv_asn(inv_asn)
    );

    function automatic logic [63:0] mget(int i);
        return m.exists(i) ? m[i] : 64'h0;
    endfunction

    function automatic bit m_rd_ok(int i);
        return (i < 4) || (i >= 8 && i <= 25);
    endfunction

    function automatic bit m_wr_ok(int i);
        return (i < 4) || (i >= 8 && i <= 16) || (i >= 21 && i <= 25) || (i >= 32 && i <= 38);
    endfunction

    function automatic logic [63:0] m_read(int i);
        if (!m_rd_ok(i)) return 64'h0;
        if (i == 25) return {mget(25)[63:32], m_cnt};
        return mget(i);
    endfunction

    function automatic logic [63:0] shape(int i, logic [63:0] v);
        case (i)
            10:      return v & ~64'h2;
            11, 12:  return v & 64'hF;
            13, 14:  return v & 64'h18;
            21:      return v & 64'h7F0;
            22:      return v & 64'hFE00_0000_0000_0000;
            23:      return v & 64'hFFFF_FFFF_C000_0000;
            24:      return v & 64'h3F;
            25:      return v & 64'hFFFF_FFFF_0000_0000;
            default: return v;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive, compare at mid-low phase, clock, update model
    task automatic step(string tag, int i, bit w, bit r, logic [63:0] wd,
                        logic [63:0] post = 64'h0);
        idx = 6'(i); wr_en = w; rd_en = r; wdata = wd; exc_post = post;
        #0.5;
        chk(tag, "rdata", rdata, r ? m_read(i) : 64'h0);
        chk(tag, "fault", 64'(fault), 64'((r && !m_rd_ok(i)) || (w && !m_wr_ok(i))));
        chk(tag, "user_mode", 64'(user_mode), 64'(mget(14) != 0));
        chk(tag, "inv_pulses", {61'b0, inv_all_p, inv_proc_p, inv_one_p},
            {61'b0, e_all, e_proc, e_one});
        if (e_one) begin
            chk(tag, "inv_addr", inv_addr, e_addr);
            chk(tag, "inv_asn", 64'(inv_asn), 64'(e_asn));
        end
        @(posedge clk);
        m_cnt++;
        e_all  = w && i == 36;
        e_proc = w && i == 37;
        e_one  = w && i == 38;
        if (e_one) begin
            e_addr = wd;
            e_asn  = mget(21)[10:4];
        end
        if (w && m_wr_ok(i) && i != 15 && i != 16 && i < 32) m[i] = shape(i, wd);
        m[15] = ((w && i == 15) ? 64'h0 : mget(15)) | post;
        m[16] = ((w && i == 16) ? 64'h0 : mget(16)) | post;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m[8] = VEC; m[9] = 64'h6; m_cnt = 0;
        e_all = 0; e_proc = 0; e_one = 0; e_addr = '0; e_asn = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        step("R1", 9, 0, 1, 0);
        step("R1", 8, 0, 1, 0);
        step("R1", 0, 0, 1, 0);
        step("R1", 22, 0, 1, 0);
        step("R1", 25, 0, 1, 0);
        // R13 no read strobe
        step("R13", 9, 0, 0, 0);
        // R2 full writes
        step("R2", 0, 1, 0, 64'hDEAD_BEEF_0123_4567);
        step("R2", 3, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R2", 0, 0, 1, 0);
        step("R2", 3, 0, 1, 0);
        step("R2", 9, 1, 1, 64'hA5A5_5A5A_0F0F_F0F0);
        step("R2", 9, 0, 1, 0);
        step("R2", 25, 1, 0, 64'h1234_5678_9ABC_DEF0);
        // R11 splice
        step("R11", 25, 0, 1, 0);
        step("R11", 25, 0, 1, 0);
        // R3
        step("R3", 10, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R3", 10, 0, 1, 0);
        // R4
        step("R4", 11, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R4", 12, 1, 0, 64'h0000_0000_0000_00A5);
        step("R4", 11, 0, 1, 0);
        step("R4", 12, 0, 1, 0);
        // R5
        step("R5", 14, 1, 0, 64'h8);
        step("R5", 14, 0, 1, 0);
        step("R5", 14, 1, 0, 64'hFFFF_FFFF_FFFF_FFE7);
        step("R5", 14, 0, 1, 0);
        step("R5", 13, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R5", 13, 0, 1, 0);
        // R6
        step("R6", 21, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R6", 22, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R6", 23, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R6", 24, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int i = 21; i <= 24; i++) step("R6", i, 0, 1, 0);
        // R7
        step("R7", 0, 0, 0, 0, 64'h0000_0000_0000_0F00);
        step("R7", 15, 0, 1, 0);
        step("R7", 16, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R7", 16, 0, 1, 0);
        step("R7", 15, 1, 0, 64'h0, 64'h0000_0000_0000_0003);
        step("R7", 15, 0, 1, 0);
        // R8
        for (int i = 17; i <= 20; i++) step("R8", i, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int i = 17; i <= 20; i++) step("R8", i, 0, 1, 0);
        // R9
        for (int i = 32; i <= 38; i++) step("R9", i, 0, 1, 0);
        for (int i = 32; i <= 35; i++) step("R9", i, 1, 0, 64'h55);
        // R10 unassigned
        for (int i = 4; i <= 7; i++) step("R10", i, 1, 1, 64'h1);
        for (int i = 26; i <= 31; i++) step("R10", i, 0, 1, 0);
        for (int i = 39; i <= 63; i += 6) step("R10", i, 1, 0, 64'h1);
        step("R10", 63, 1, 1, 64'h1);
        // R12 invalidate pulses
        step("R12", 21, 1, 0, 64'h0000_0000_0000_05A0);
        step("R12", 36, 1, 0, 64'hFFFF);
        step("R12", 37, 1, 0, 64'hFFFF);
        step("R12", 38, 1, 0, 64'hCAFE_0000_1234_0000);
        step("R12", 21, 1, 0, 64'h7F0);
        step("R12", 38, 1, 0, 64'h0000_0000_0000_BEEF);
        step("R12", 0, 0, 0, 0);
        // random mix, compared every clock
        for (int n = 0; n < 3000; n++) begin
            int i;
            logic [63:0] wd, pv;
            i  = $urandom_range(0, 63);
            wd = {$urandom, $urandom};
            pv = ($urandom_range(0, 7) == 0) ? {$urandom, $urandom} : 64'h0;
            step("R11", i, 1'($urandom), 1'($urandom), wd, pv);
        end
        // R11 final counter view
        step("R11", 25, 0, 1, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule